// File: doc/BRIEF.md
# Cartridge Outer Bank Register File

This block keeps the four 8-bit outer banking registers that a multicart controller decodes in its $6000-$7FFF CPU write window. A qualified write strobe, together with CPU address bits [1:0], picks one register. The register that holds the fixed-size CHR bank does not accept every write in full. Some of its bits are write-protected, and its own current contents decide which ones. A lock flag in the mode register stops all writes to the other three registers. The write also reaches cartridge RAM, but that path lies outside this block.

The block also models a small DIP-style selector. Power-on clears it and each soft reset advances it by one. When the substitution flag in register 1 is set, PRG ROM reads take the selector's low bit in place of CPU address bit 0. Downstream banking logic reads the four register values and the selector bit. The PRG address path reads the substituted address bit.

Top module: `outer_bank_regs`

## Requirements
- R1: A write with `wr_en` high stores into the register numbered by `wr_addr` (0 to 3). The new value shows on that register's output from the cycle after the write. The other three registers keep their values.
- R2: Writes to register 2 are applied whatever the state of the lock flag (register 3 bit 7).
- R3: While register 2 bit 7 is 1, a write to register 2 leaves its bits 7:4 unchanged.
- R4: Register 2 bits 6, 5 and 4, when set, protect register 2 bits 3, 2 and 1 against writes. The protection is taken from the value held before the write. Bit 0 of register 2 is never protected.
- R5: While register 3 bit 7 is 1, writes to registers 0, 1 and 3 have no effect. This includes any write that would clear the lock itself.
- R6: Power-on reset (`rst`) clears all four registers and the selector to zero.
- R7: A soft reset pulse (`soft_rst`) clears all four registers and adds one to the selector. `sel_bit` shows bit 0 of the selector, so it toggles on every soft reset.
- R8: While register 1 bit 0 is 1, `prg_a0` equals `sel_bit`. Otherwise it equals `cpu_a0`.
- R9: When a soft reset and a write fall in the same cycle, the soft reset wins and the registers read zero afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| soft_rst | input | 1 | Soft reset pulse, one cycle |
| wr_en | input | 1 | Qualified write strobe for the $6000-$7FFF window |
| wr_addr | input | 2 | CPU address bits [1:0], selects the register |
| wr_data | input | 8 | CPU data bus |
| cpu_a0 | input | 1 | CPU address bit 0 of a PRG read |
| bank0 | output | 8 | Register 0 value |
| bank1 | output | 8 | Register 1 value (bit 0 is the address substitution flag) |
| bank2 | output | 8 | Register 2 value (fixed-size CHR bank with protection bits) |
| bank3 | output | 8 | Register 3 value (bit 7 is the lock flag) |
| sel_bit | output | 1 | Selector bit 0 |
| prg_a0 | output | 1 | Address bit 0 passed on to PRG ROM |

## Verification
The bench uses the default selector width of two bits. Two soft resets return the low bit to zero, but the counter itself does not wrap back until the fourth. A run of four soft resets therefore shows that only bit 0 reaches the ports, whatever the count. The table of writes drives register 2 through progressively stronger protection, from none, to a single low bit, to the full upper nibble. It also hits every locked register both before and after the lock is set.

// File: rtl/obr_pkg.sv
package obr_pkg;

    localparam int DATA_W    = 8;
    localparam int NUM_REGS  = 4;
    localparam int IDX_W     = $clog2(NUM_REGS);

    // Register roles and bit positions the neighbouring logic decodes
    localparam int IDX_SUBST = 1;
    localparam int IDX_CHR   = 2;
    localparam int IDX_MODE  = 3;
    localparam int LOCK_BIT  = 7;
    localparam int SUBST_BIT = 0;
    localparam int GUARD_BIT = 7;

    typedef logic [DATA_W-1:0] byte_t;

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] idx;
        byte_t            data;
    } wr_req_t;

    // Bits of the CHR register that a write must leave untouched
    function automatic byte_t chr_guard_mask(input byte_t cur);
        byte_t m;
        m = '0;
        if (cur[GUARD_BIT]) m[7:4] = 4'hF;
        m[3:1] = m[3:1] | cur[6:4];
        return m;
    endfunction

endpackage

// File: rtl/obr_write_decode.sv
module obr_write_decode
    import obr_pkg::*;
(
    input  wr_req_t             req,
    input  logic                locked,
    output logic [NUM_REGS-1:0] hit
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
        if (i == IDX_CHR) begin : g_free
            assign hit[i] = req.en && (req.idx == IDX_W'(i));
        end else begin : g_gated
            assign hit[i] = req.en && !locked && (req.idx == IDX_W'(i));
        end
    end
endmodule

// File: rtl/obr_plain_reg.sv
module obr_plain_reg
    import obr_pkg::*;
(
    input  logic  clk,
    input  logic  clr,
    input  logic  load,
    input  byte_t din,
    output byte_t q
);
    always_ff @(posedge clk) begin
        if (clr)
            q <= '0;
        else if (load)
            q <= din;
    end
endmodule

// File: rtl/obr_chr_reg.sv
module obr_chr_reg
    import obr_pkg::*;
(
    input  logic  clk,
    input  logic  clr,
    input  logic  load,
    input  byte_t din,
    output byte_t q
);
    byte_t guard;

    always_comb guard = chr_guard_mask(q);

    always_ff @(posedge clk) begin
        if (clr)
            q <= '0;
        else if (load)
            q <= (q & guard) | (din & ~guard);
    end
endmodule

// File: rtl/obr_selector.sv
module obr_selector #(
    parameter int SEL_W = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    output logic low_bit
);
    logic [SEL_W-1:0] count;

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (step)
            count <= count + SEL_W'(1);
    end

    assign low_bit = count[0];
endmodule

// File: rtl/outer_bank_regs.sv
module outer_bank_regs
    import obr_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       soft_rst,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       cpu_a0,
    output logic [7:0] bank0,
    output logic [7:0] bank1,
    output logic [7:0] bank2,
    output logic [7:0] bank3,
    output logic       sel_bit,
    output logic       prg_a0
);
    wr_req_t             req;
    logic [NUM_REGS-1:0] hit;
    byte_t               regs_q [NUM_REGS];
    logic                clr_all;

    assign req     = '{en: wr_en, idx: wr_addr, data: wr_data};
    assign clr_all = rst || soft_rst;

    obr_write_decode u_dec (
        .req    (req),
        .locked (regs_q[IDX_MODE][LOCK_BIT]),
        .hit    (hit)
    );

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        if (i == IDX_CHR) begin : g_chr
            obr_chr_reg u_r (
                .clk  (clk),
                .clr  (clr_all),
                .load (hit[i]),
                .din  (req.data),
                .q    (regs_q[i])
            );
        end else begin : g_plain
            obr_plain_reg u_r (
                .clk  (clk),
                .clr  (clr_all),
                .load (hit[i]),
                .din  (req.data),
                .q    (regs_q[i])
            );
        end
    end

    obr_selector #(.SEL_W(SEL_W)) u_sel (
        .clk     (clk),
        .rst     (rst),
        .step    (soft_rst),
        .low_bit (sel_bit)
    );

    assign bank0  = regs_q[0];
    assign bank1  = regs_q[1];
    assign bank2  = regs_q[2];
    assign bank3  = regs_q[3];
    assign prg_a0 = regs_q[IDX_SUBST][SUBST_BIT] ? sel_bit : cpu_a0;
endmodule

// File: rtl/obr_checker.sv
module obr_checker (
    input logic       clk,
    input logic       rst,
    input logic       soft_rst,
    input logic       wr_en,
    input logic [1:0] wr_addr,
    input logic [7:0] bank0,
    input logic [7:0] bank1,
    input logic [7:0] bank2,
    input logic [7:0] bank3,
    input logic       sel_bit
);
    // R6
    por_clear_chk: assert property (@(posedge clk)
        rst |=> (bank0 == 8'h00 && bank1 == 8'h00 && bank2 == 8'h00 && bank3 == 8'h00 && !sel_bit));

    // R7
    soft_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (sel_bit != $past(sel_bit)));

    // R9
    soft_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (soft_rst && wr_en) |=> (bank0 == 8'h00 && bank1 == 8'h00 && bank2 == 8'h00 && bank3 == 8'h00));

    // R5
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !soft_rst && wr_addr != 2'd2 && bank3[7]) |=> ($stable(bank0) && $stable(bank1) && $stable(bank3)));

    // R3
    upper_guard_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !soft_rst && wr_addr == 2'd2 && bank2[7]) |=> (bank2[7:4] == $past(bank2[7:4])));

    // R1
    other_regs_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !soft_rst && wr_addr == 2'd2) |=> ($stable(bank0) && $stable(bank1) && $stable(bank3)));

    // R7
    sel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !soft_rst |=> $stable(sel_bit));
endmodule

bind outer_bank_regs obr_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .soft_rst (soft_rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .bank0    (bank0),
    .bank1    (bank1),
    .bank2    (bank2),
    .bank3    (bank3),
    .sel_bit  (sel_bit)
);

// File: tb/sim_outer_bank_regs.sv
module sim_outer_bank_regs;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       soft_rst = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       cpu_a0 = 1'b0;
    logic [7:0] bank0, bank1, bank2, bank3;
    logic       sel_bit, prg_a0;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    outer_bank_regs u0 (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .cpu_a0(cpu_a0),
        .bank0(bank0), .bank1(bank1), .bank2(bank2), .bank3(bank3),
        .sel_bit(sel_bit), .prg_a0(prg_a0)
    );

    // {addr, data, expected bank0, bank1, bank2, bank3}
    localparam int NVEC = 12;
    localparam logic [41:0] VEC [NVEC] = '{
        {2'd0, 8'h5A, 8'h5A, 8'h00, 8'h00, 8'h00},  // R1
        {2'd1, 8'h01, 8'h5A, 8'h01, 8'h00, 8'h00},  // R1
        {2'd2, 8'h13, 8'h5A, 8'h01, 8'h13, 8'h00},  // R1 no guard yet
        {2'd2, 8'h2C, 8'h5A, 8'h01, 8'h2E, 8'h00},  // R4 bit1 held
        {2'd2, 8'hF1, 8'h5A, 8'h01, 8'hF5, 8'h00},  // R4 bit2 held
        {2'd2, 8'h00, 8'h5A, 8'h01, 8'hF4, 8'h00},  // R3 R4 upper + 3:1 held
        {2'd3, 8'h08, 8'h5A, 8'h01, 8'hF4, 8'h08},  // R1
        {2'd3, 8'h80, 8'h5A, 8'h01, 8'hF4, 8'h80},  // R5 set lock
        {2'd0, 8'hFF, 8'h5A, 8'h01, 8'hF4, 8'h80},  // R5
        {2'd1, 8'h00, 8'h5A, 8'h01, 8'hF4, 8'h80},  // R5
        {2'd3, 8'h00, 8'h5A, 8'h01, 8'hF4, 8'h80},  // R5 lock self-held
        {2'd2, 8'h0B, 8'h5A, 8'h01, 8'hF5, 8'h80}   // R2 R3 R4 bit0 free
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_banks(input string req, input logic [31:0] exp);
        check(req, {bank0, bank1, bank2, bank3}, exp);
    endtask

    // Drive at a falling edge, one rising edge, sample at the next falling edge
    task automatic cpu_write(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic pulse_soft(input logic with_write);
        soft_rst = 1'b1;
        wr_en = with_write; wr_addr = 2'd0; wr_data = 8'hAA;
        @(negedge clk);
        soft_rst = 1'b0; wr_en = 1'b0;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check_banks("R6 reset banks", 32'h0);
        check("R6 reset sel", {31'd0, sel_bit}, 32'd0);
        cpu_a0 = 1'b1; #1;
        check("R8 passthrough", {31'd0, prg_a0}, 32'd1);

        @(negedge clk);
        for (int i = 0; i < NVEC; i++) begin
            cpu_write(VEC[i][41:40], VEC[i][39:32]);
            check_banks($sformatf("R1 R2 R3 R4 R5 vec %0d", i), VEC[i][31:0]);
        end

        // R8 substitution on, selector 0, cpu_a0 1
        cpu_a0 = 1'b1; #1;
        check("R8 substituted", {31'd0, prg_a0}, 32'd0);

        // R7 and R9 soft reset with a write in the same cycle
        @(negedge clk);
        pulse_soft(1'b1);
        check_banks("R9 soft beats write", 32'h0);
        check("R7 sel after one", {31'd0, sel_bit}, 32'd1);
        check("R8 flag cleared", {31'd0, prg_a0}, 32'd1);

        // R8 substitution with selector 1, cpu_a0 0
        @(negedge clk);
        cpu_write(2'd1, 8'h01);
        cpu_a0 = 1'b0; #1;
        check("R8 sel drives a0", {31'd0, prg_a0}, 32'd1);

        // R7 low bit only: toggles through a full selector cycle
        for (int k = 2; k <= 5; k++) begin
            @(negedge clk);
            pulse_soft(1'b0);
            check($sformatf("R7 sel after %0d", k), {31'd0, sel_bit}, k % 2);
        end
        check_banks("R7 soft clears", 32'h0);

        // R6 power-on clears selector after it was set
        @(negedge clk);
        cpu_write(2'd0, 8'h33);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; #1;
        check_banks("R6 por banks", 32'h0);
        check("R6 por sel", {31'd0, sel_bit}, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule